// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Timeout

This block sits between a host register port and the byte-wide handshake of an enhanced parallel port peripheral. The host reaches a small register window: a control register, a status register, an address-cycle register (offset 3) and a data-cycle register (offset 4). An access to either cycle register reaches the peripheral only when the direction bit and the four line-signal bits of the control register hold the one exact pattern that belongs to that direction. Any other access to those offsets is dropped without a trace on the peripheral side.

A permitted access moves one byte (address register) or 1, 2 or 4 bytes (data register, least significant byte first). Each byte is a request/acknowledge exchange whose length is bounded by a programmable cycle limit. A byte that is not acknowledged in time aborts the access and sets a sticky timeout flag, which the host sees in bit 0 of status and clears by writing status with bit 0 set.

The host request channel and the response channel are both valid/ready. A request is taken on a cycle where `host_valid` and `host_ready` are both high; `host_ready` then stays low until the response has been taken. The response (`rsp_valid`, `rsp_rdata`) is held unchanged for as long as `rsp_ready` stays low, so the host may apply back-pressure for any number of cycles.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset the control register reads 0x0C, status reads 0x00, `host_ready` is high, `rsp_valid` is low and `per_req` is low.
- R2: A write to offset 3 or 4 reaches the peripheral only when (control AND 0x2F) equals 0x04; control bits 4, 6 and 7 have no influence on the gate.
- R3: A read from offset 3 or 4 reaches the peripheral only when (control AND 0x2F) equals 0x24.
- R4: A gated-off access raises no `per_req` and leaves the timeout flag unchanged; a gated-off read returns all ones in the bytes of its width and zero above.
- R5: Size code 0, 1, 2 or 3 on `host_size` moves 1, 2, 4 or 4 bytes through offset 4, least significant byte first on both write data and read assembly; offset 3 always moves one byte with `per_addr_sel` high, whatever the size.
- R6: `per_req` stays high until `per_ack` is seen or the limit expires, drops for at least one cycle between bytes, and `per_wbyte`, `per_read` and `per_addr_sel` are stable while it is high.
- R7: A byte not acknowledged within `cfg_limit` request cycles (a limit of 0 acts as 1) ends the access, sets the sticky timeout flag and launches no further byte of that access; bytes not received read as 0xFF.
- R8: Status reads return the timeout flag in bit 0 and zero elsewhere; a status write with bit 0 set clears the flag, one with bit 0 clear leaves it.
- R9: `host_ready` is low from acceptance until the response is taken, never high together with `rsp_valid`, and `rsp_rdata` is stable while `rsp_valid` waits on `rsp_ready`; write responses carry zero.
- R10: Offset 2 stores and returns all eight bits written; offsets 0, 5, 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can take a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Access size code (0:1, 1:2, 2/3:4 bytes) |
| host_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| cfg_limit | input | 8 | Request cycles allowed per byte |
| per_req | output | 1 | Byte request to the peripheral |
| per_addr_sel | output | 1 | 1 = address cycle, 0 = data cycle |
| per_read | output | 1 | 1 = peripheral drives the byte |
| per_wbyte | output | 8 | Byte sent on write cycles |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rbyte | input | 8 | Byte returned on read cycles |

## Verification
The assertions take for granted that the peripheral raises `per_ack` only while `per_req` is high and drops it once the request falls, and that `cfg_limit` does not change while an access is running. The bench's peripheral model answers each request after a chosen delay, or never on one chosen byte, and releases the acknowledge on the first clock edge with the request low; the limit is only changed between accesses. Control is swept over all 256 values, and every size, delay around the limit and abort position is exercised against arithmetically predicted byte traces.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam logic [7:0] CTRL_GATE_MASK = 8'h2F;
  localparam logic [7:0] CTRL_WR_PATTERN = 8'h04;
  localparam logic [7:0] CTRL_RD_PATTERN = 8'h24;
  localparam logic [7:0] CTRL_RESET_VAL  = 8'h0C;

  localparam logic [2:0] OFF_STATUS = 3'd1;
  localparam logic [2:0] OFF_CTRL   = 3'd2;
  localparam logic [2:0] OFF_EADDR  = 3'd3;
  localparam logic [2:0] OFF_EDATA  = 3'd4;

  typedef enum logic [1:0] {ACC_IDLE, ACC_RUN, ACC_RESP} acc_state_t;
  typedef enum logic [1:0] {BX_IDLE, BX_REQ, BX_GAP} bx_state_t;
endpackage

// File: rtl/epp_ctrl_regs.sv
module epp_ctrl_regs
  import epp_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_status,
  input  logic [7:0] wdata,
  input  logic       set_tmo,
  output logic [7:0] ctrl,
  output logic       tmo_flag,
  output logic       wr_permit,
  output logic       rd_permit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= CTRL_RESET_VAL;
      tmo_flag <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wdata;
      if (set_tmo) tmo_flag <= 1'b1;
      else if (wr_status && wdata[0]) tmo_flag <= 1'b0;
    end
  end

  assign wr_permit = (ctrl & CTRL_GATE_MASK) == CTRL_WR_PATTERN;
  assign rd_permit = (ctrl & CTRL_GATE_MASK) == CTRL_RD_PATTERN;

  // R7
  tmo_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(set_tmo));
  // R8
  tmo_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_flag) |-> ($past(wr_status) && $past(wdata[0])));
endmodule

// File: rtl/epp_byte_xfer.sv
module epp_byte_xfer
  import epp_gate_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               ack,
  input  logic [7:0]         rbyte_in,
  output logic               req,
  output logic               done,
  output logic               timed_out,
  output logic [7:0]         rbyte
);
  bx_state_t          state;
  logic [LIMIT_W-1:0] cnt;
  logic [LIMIT_W:0]   cnt_next;
  logic               expire;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign expire   = cnt_next >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= BX_IDLE;
      cnt       <= '0;
      timed_out <= 1'b0;
      rbyte     <= '0;
    end else begin
      case (state)
        BX_REQ: begin
          if (ack) begin
            rbyte     <= rbyte_in;
            timed_out <= 1'b0;
            state     <= BX_GAP;
          end else if (expire) begin
            timed_out <= 1'b1;
            state     <= BX_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (start) begin
            cnt   <= '0;
            state <= BX_REQ;
          end else begin
            state <= BX_IDLE;
          end
        end
      endcase
    end
  end

  assign req  = state == BX_REQ;
  assign done = state == BX_GAP;

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req);
  // R7
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && (cnt_next >= {1'b0, limit})) |=> (done && timed_out));
endmodule

// File: rtl/epp_lane_pack.sv
module epp_lane_pack #(
  parameter int BUS_BYTES = 4,
  localparam int IDX_W = $clog2(BUS_BYTES),
  localparam int BUS_W = 8 * BUS_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] wdata,
  input  logic [IDX_W-1:0] idx,
  input  logic             capture,
  input  logic [7:0]       cap_byte,
  output logic [7:0]       cur_byte,
  output logic [BUS_W-1:0] rbuf
);
  logic [BUS_W-1:0] wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf <= '0;
      rbuf <= '1;
    end else if (load) begin
      wbuf <= wdata;
      rbuf <= '1;
    end else if (capture) begin
      for (int i = 0; i < BUS_BYTES; i++)
        if (idx == IDX_W'(i)) rbuf[i*8 +: 8] <= cap_byte;
    end
  end

  assign cur_byte = wbuf[idx*8 +: 8];
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int BUS_BYTES = 4,
  parameter int LIMIT_W   = 8,
  localparam int BUS_W = 8 * BUS_BYTES,
  localparam int IDX_W = $clog2(BUS_BYTES),
  localparam int CNT_W = $clog2(BUS_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_write,
  input  logic [2:0]         host_addr,
  input  logic [1:0]         host_size,
  input  logic [BUS_W-1:0]   host_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BUS_W-1:0]   rsp_rdata,
  input  logic [LIMIT_W-1:0] cfg_limit,
  output logic               per_req,
  output logic               per_addr_sel,
  output logic               per_read,
  output logic [7:0]         per_wbyte,
  input  logic               per_ack,
  input  logic [7:0]         per_rbyte
);
  acc_state_t       state;
  logic             accept, is_epp, permit, launch;
  logic [CNT_W-1:0] nb_d, nb_q;
  logic [IDX_W-1:0] idx;
  logic             acc_write, from_eng, last_byte;
  logic [BUS_W-1:0] mask_d, mask_q, imm_d, imm_q, rbuf;
  logic [7:0]       ctrl;
  logic             tmo_flag, wr_permit, rd_permit;
  logic             bx_start, bx_done, bx_tmo, capture, set_tmo;
  logic [7:0]       bx_rbyte;

  assign host_ready = state == ACC_IDLE;
  assign rsp_valid  = state == ACC_RESP;
  assign accept     = host_valid && host_ready;
  assign is_epp     = (host_addr == OFF_EADDR) || (host_addr == OFF_EDATA);
  assign permit     = host_write ? wr_permit : rd_permit;
  assign launch     = accept && is_epp && permit;

  always_comb begin
    if (host_addr == OFF_EADDR) nb_d = CNT_W'(1);
    else case (host_size)
      2'd0:    nb_d = CNT_W'(1);
      2'd1:    nb_d = CNT_W'(2);
      default: nb_d = CNT_W'(BUS_BYTES);
    endcase
  end

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane_mask
    assign mask_d[g*8 +: 8] = (CNT_W'(g) < nb_d) ? 8'hFF : 8'h00;
    assign mask_q[g*8 +: 8] = (CNT_W'(g) < nb_q) ? 8'hFF : 8'h00;
  end

  always_comb begin
    imm_d = '0;
    if (!host_write) begin
      case (host_addr)
        OFF_STATUS:           imm_d = BUS_W'(tmo_flag);
        OFF_CTRL:             imm_d = BUS_W'(ctrl);
        OFF_EADDR, OFF_EDATA: imm_d = mask_d;
        default:              imm_d = '0;
      endcase
    end
  end

  assign last_byte = (CNT_W'(idx) + 1'b1) == nb_q;
  assign capture   = (state == ACC_RUN) && bx_done && !bx_tmo && !acc_write;
  assign set_tmo   = (state == ACC_RUN) && bx_done && bx_tmo;
  assign bx_start  = launch || ((state == ACC_RUN) && bx_done && !bx_tmo && !last_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ACC_IDLE;
      nb_q         <= '0;
      idx          <= '0;
      acc_write    <= 1'b0;
      from_eng     <= 1'b0;
      imm_q        <= '0;
      per_addr_sel <= 1'b0;
      per_read     <= 1'b0;
    end else begin
      case (state)
        ACC_IDLE: if (accept) begin
          acc_write    <= host_write;
          nb_q         <= nb_d;
          idx          <= '0;
          from_eng     <= launch;
          imm_q        <= imm_d;
          per_addr_sel <= host_addr == OFF_EADDR;
          per_read     <= !host_write;
          state        <= launch ? ACC_RUN : ACC_RESP;
        end
        ACC_RUN: if (bx_done) begin
          if (bx_tmo || last_byte) state <= ACC_RESP;
          else idx <= idx + 1'b1;
        end
        default: if (rsp_ready) state <= ACC_IDLE;
      endcase
    end
  end

  assign rsp_rdata = from_eng ? (acc_write ? '0 : (rbuf & mask_q)) : imm_q;

  epp_ctrl_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(accept && host_write && host_addr == OFF_CTRL),
    .wr_status(accept && host_write && host_addr == OFF_STATUS),
    .wdata(host_wdata[7:0]), .set_tmo(set_tmo),
    .ctrl(ctrl), .tmo_flag(tmo_flag),
    .wr_permit(wr_permit), .rd_permit(rd_permit)
  );

  epp_byte_xfer #(.LIMIT_W(LIMIT_W)) i_xfer (
    .clk(clk), .rst_n(rst_n), .start(bx_start), .limit(cfg_limit),
    .ack(per_ack), .rbyte_in(per_rbyte), .req(per_req),
    .done(bx_done), .timed_out(bx_tmo), .rbyte(bx_rbyte)
  );

  epp_lane_pack #(.BUS_BYTES(BUS_BYTES)) i_pack (
    .clk(clk), .rst_n(rst_n), .load(launch), .wdata(host_wdata),
    .idx(idx), .capture(capture), .cap_byte(bx_rbyte),
    .cur_byte(per_wbyte), .rbuf(rbuf)
  );

  // R2 R3
  gate_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> ((ctrl & CTRL_GATE_MASK) == (per_read ? CTRL_RD_PATTERN : CTRL_WR_PATTERN)));
  // R6
  wbyte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && !per_ack) |=> ($stable(per_wbyte) && $stable(per_read) && $stable(per_addr_sel)));
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ready && rsp_valid));
endmodule

// File: tb/test_epp_cycle_gate.sv
module test_epp_cycle_gate;
  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_write = 0, rsp_ready = 0, per_ack = 0;
  logic [2:0] host_addr = 0;
  logic [1:0] host_size = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0] cfg_limit = 8'd4, per_rbyte = 0;
  logic host_ready, rsp_valid, per_req, per_addr_sel, per_read;
  logic [31:0] rsp_rdata;
  logic [7:0] per_wbyte;

  int checks = 0, errors = 0;
  int dly = 0, fail_at = -1, att = 0, oks = 0, gbyte = 0, hc = 0;
  bit prev_req = 0, bad_stable = 0;
  logic [7:0] lw [8];
  bit lsel [8], lrd [8];

  always #2.5 clk = ~clk;

  epp_cycle_gate i_epp_cycle_gate (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_size(host_size),
    .host_wdata(host_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .cfg_limit(cfg_limit), .per_req(per_req),
    .per_addr_sel(per_addr_sel), .per_read(per_read), .per_wbyte(per_wbyte),
    .per_ack(per_ack), .per_rbyte(per_rbyte));

  function automatic logic [7:0] fbyte(int n);
    return 8'(8'h3C + n * 29);
  endfunction

  // peripheral model
  always @(negedge clk) begin
    if (rst_n && per_req) begin
      if (!prev_req) begin att++; hc = 0; end
      if (!per_ack) begin
        if ((att - 1) != fail_at && hc >= dly) begin
          per_ack = 1; per_rbyte = fbyte(gbyte); gbyte++;
          if (oks < 8) begin lw[oks] = per_wbyte; lsel[oks] = per_addr_sel; lrd[oks] = per_read; end
          oks++;
        end else hc++;
      end
    end else begin
      per_ack = 0; hc = 0;
    end
    prev_req = per_req;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input [2:0] a, input [1:0] sz, input [31:0] wd,
                     output [31:0] rd, input int hold = 0);
    att = 0; oks = 0;
    @(negedge clk);
    host_valid = 1; host_write = w; host_addr = a; host_size = sz; host_wdata = wd;
    while (!host_ready) @(negedge clk);
    @(negedge clk); host_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!rsp_valid || host_ready || rsp_rdata !== rd) bad_stable = 1;
    end
    rsp_ready = 1;
    @(negedge clk); rsp_ready = 0;
  endtask

  function automatic int nbytes(bit [2:0] a, bit [1:0] sz);
    if (a == 3) return 1;
    return sz == 0 ? 1 : sz == 1 ? 2 : 4;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp;
    int base, n, good;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 host_ready", host_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 per_req", per_req, 0);
    acc(0, 2, 0, 0, rd); chk("R1 ctrl reset", rd, 32'h0C);
    acc(0, 1, 0, 0, rd); chk("R1 status reset", rd, 0);
    acc(0, 4, 0, 0, rd); chk("R4 read gated at reset", rd, 32'hFF);
    chk("R4 no request at reset", att, 0);

    // R2 R3 R10 sweep of every control value
    dly = 0; cfg_limit = 4;
    for (int c = 0; c < 256; c++) begin
      acc(1, 2, 0, 32'(c), rd);
      acc(0, 2, 0, 0, rd); chk("R10 ctrl readback", rd, 32'(c));
      acc(1, 4, 0, 32'h5500 + 32'(c), rd);
      good = ((c & 8'h2F) == 8'h04);
      chk("R2 write gate", att, good);
      if (good) chk("R2 write byte", lw[0], 8'(8'h00 + c));
      base = gbyte;
      acc(0, 4, 0, 0, rd);
      good = ((c & 8'h2F) == 8'h24);
      chk("R3 read gate", att, good);
      chk("R3 R4 read value", rd, good ? 32'(fbyte(base)) : 32'hFF);
    end

    // R4 gated reads of each width; flag untouched
    acc(1, 2, 0, 32'h0C, rd);
    for (int s = 0; s < 4; s++) begin
      acc(0, 4, 2'(s), 0, rd); n = nbytes(4, 2'(s));
      chk("R4 gated width", rd, n == 4 ? 32'hFFFFFFFF : (32'd1 << (8*n)) - 1);
      acc(1, 3, 2'(s), 32'h12345678, rd); chk("R4 gated write no req", att, 0);
    end
    acc(0, 1, 0, 0, rd); chk("R4 flag untouched", rd, 0);

    // R5 R6 R7 widths x delays around limit
    cfg_limit = 3;
    for (int dir = 0; dir < 2; dir++)
      for (int a = 3; a <= 4; a++)
        for (int s = 0; s < 4; s++)
          for (int d = 1; d <= 4; d++) begin
            acc(1, 2, 0, dir ? 32'h24 : 32'h04, rd);
            dly = d; fail_at = -1; n = nbytes(3'(a), 2'(s)); base = gbyte;
            acc(dir == 0, 3'(a), 2'(s), 32'hA1B2C3D4, rd);
            good = d < 3;
            chk("R7 attempts", att, good ? n : 1);
            chk("R5 bytes moved", oks, good ? n : 0);
            if (good) for (int i = 0; i < n; i++) begin
              if (dir == 0) chk("R5 write order", lw[i], 8'(32'hA1B2C3D4 >> (8*i)));
              chk("R5 addr_sel", lsel[i], a == 3);
              chk("R6 read dir", lrd[i], dir);
            end
            exp = 0;
            if (dir) for (int i = 0; i < n; i++)
              exp[8*i +: 8] = good ? fbyte(base + i) : 8'hFF;
            chk("R5 R7 rdata", rd, exp);
            acc(0, 1, 0, 0, rd); chk("R7 R8 flag", rd, good ? 0 : 1);
            if (!good) begin
              acc(1, 1, 0, 32'hFE, rd);
              acc(0, 1, 0, 0, rd); chk("R8 bit0 clear keeps flag", rd, 1);
              acc(1, 1, 0, 32'h01, rd);
              acc(0, 1, 0, 0, rd); chk("R8 flag cleared", rd, 0);
            end
          end

    // R7 abort position in 4-byte accesses
    dly = 0; cfg_limit = 5;
    for (int dir = 0; dir < 2; dir++)
      for (int f = 0; f <= 4; f++) begin
        acc(1, 2, 0, dir ? 32'h24 : 32'h04, rd);
        fail_at = f; base = gbyte;
        acc(dir == 0, 4, 2, 32'h0F1E2D3C, rd);
        chk("R7 abort attempts", att, f < 4 ? f + 1 : 4);
        chk("R7 abort ok bytes", oks, f);
        exp = '1;
        if (dir) for (int i = 0; i < f; i++) exp[8*i +: 8] = fbyte(base + i);
        else exp = 0;
        chk("R7 partial rdata", rd, exp);
        acc(0, 1, 0, 0, rd); chk("R7 sticky", rd, f < 4);
        acc(1, 1, 0, 32'h01, rd);
      end
    fail_at = -1;

    // R7 limit zero behaves as one
    cfg_limit = 0; acc(1, 2, 0, 32'h04, rd);
    dly = 0; acc(1, 4, 0, 32'h77, rd); chk("R7 limit0 ok", oks, 1);
    dly = 1; acc(1, 4, 0, 32'h77, rd); chk("R7 limit0 timeout", oks, 0);
    acc(0, 1, 0, 0, rd); chk("R7 limit0 flag", rd, 1);
    acc(1, 1, 0, 32'h01, rd);

    // R9 back-pressure and write response
    dly = 0; cfg_limit = 4;
    bad_stable = 0;
    acc(1, 2, 0, 32'h24, rd);
    base = gbyte;
    acc(0, 4, 1, 0, rd, 6);
    chk("R9 held response", bad_stable, 0);
    chk("R9 held value", rd, {16'h0, fbyte(base + 1), fbyte(base)});
    acc(1, 2, 0, 32'h04, rd);
    acc(1, 4, 2, 32'h11223344, rd); chk("R9 write rsp zero", rd, 0);

    // R10 unmapped offsets
    for (int a = 0; a < 8; a++)
      if (a == 0 || a > 4) begin
        acc(1, 3'(a), 0, 32'hFF, rd);
        acc(0, 3'(a), 0, 0, rd); chk("R10 unmapped read", rd, 0);
      end
    acc(0, 2, 0, 0, rd); chk("R10 ctrl unaffected", rd, 32'h04);
    acc(0, 1, 0, 0, rd); chk("R10 status unaffected", rd, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule